// File: doc/BRIEF.md
# Latency-Insensitive Word Memory Adapter

This block sits between a pipelined processor's memory port and a small on-chip RAM whose read path is combinational. Requests arrive over a valid/ready channel as separate fields: a kind (read or write), an opaque tag, a byte address, a length and write data. The adapter turns the byte address into a word index by subtracting a base offset and dropping the byte-select bits. It then performs the access and returns a response with the kind, tag, length and read data over a second valid/ready channel.

The RAM read settles within the cycle, so the result is captured in a single-entry response register on the accepting edge. It is offered to the processor from the next cycle on. Request ready looks ahead to a response handshake in the same cycle, so back-to-back traffic runs at one request per cycle. Two instances usually serve a processor, one for instructions and one for data. They differ only in `BASE_ADDR`.

Top module: `memadapt_top`

## Requirements
- R1: A request is taken only in a cycle where `req_val` and `req_rdy` are both high. A request offered while `req_rdy` is low neither writes the RAM nor produces a response.
- R2: `req_rdy` is high exactly when no response is held (`rsp_val` low) or `rsp_rdy` is high in the same cycle.
- R3: After a request is taken, `rsp_val` is high in the next cycle. It stays high with all response fields unchanged until a cycle in which `rsp_rdy` is high.
- R4: A response taken with no new request in the same cycle leaves `rsp_val` low in the next cycle. A response and a new request taken in the same cycle make the new response visible in the next cycle, which gives one transfer per cycle.
- R5: The word index is bits [LSB +: log2(DEPTH)] of (`req_addr` − `BASE_ADDR`) modulo 2^ADDR_W, where LSB = log2(DATA_W/8). Addresses that differ by DEPTH words alias.
- R6: A kind of 1 means write and 0 means read. A write with length 0 updates every byte of the word. A write with length k (1 ≤ k < DATA_W/8) updates only byte lanes 0 to k−1, where lane 0 is bits [7:0].
- R7: The response carries the request's kind, opaque tag and length unchanged. For a read, `rsp_data` is the word stored at the index when the request was taken.
- R8: A read never changes RAM contents, whatever `req_data` holds.
- R9: During and just after reset, `rsp_val` is low and `req_rdy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_val | input | 1 | Request offered |
| req_rdy | output | 1 | Request can be taken |
| req_type | input | 1 | 0 read, 1 write |
| req_opaque | input | OPQ_W | Tag returned with the response |
| req_addr | input | ADDR_W | Byte address |
| req_len | input | log2(DATA_W/8) | Bytes to write, 0 means all |
| req_data | input | DATA_W | Write data |
| rsp_val | output | 1 | Response held |
| rsp_rdy | input | 1 | Response can be taken |
| rsp_type | output | 1 | Kind echoed |
| rsp_opaque | output | OPQ_W | Tag echoed |
| rsp_len | output | log2(DATA_W/8) | Length echoed |
| rsp_data | output | DATA_W | Read data, undefined for writes |

## Verification
The bench builds the adapter as an instruction-side instance with `BASE_ADDR` = 0x200 and `DEPTH` = 64. The small depth lets random addresses spanning twice the array reach the aliasing rule of R5. It also lets a preload cover every word, so each random read has a known value. Offsets below the base wrap through the subtraction. Random `req_val` and `rsp_rdy` produce stalled responses, refused requests and same-cycle drain-and-refill, all checked against a byte-level model of the array.

// File: rtl/memadapt_pkg.sv
package memadapt_pkg;

   typedef enum logic {
      KIND_READ  = 1'b0,
      KIND_WRITE = 1'b1
   } msg_kind_e;

   // a length of zero selects every lane of the word
   function automatic logic lane_selected(input int unsigned lane,
                                          input int unsigned len_val);
      return (len_val == 0) || (lane < len_val);
   endfunction

endpackage

// File: rtl/memadapt_xlate.sv
module memadapt_xlate #(
   parameter int unsigned     ADDR_W    = 32,
   parameter longint unsigned BASE_ADDR = 64'h2000,
   parameter int unsigned     IDX_W     = 8,
   parameter int unsigned     LSB       = 2
) (
   input  logic [ADDR_W-1:0] byte_addr,
   output logic [IDX_W-1:0]  word_idx
);
   initial begin
      if (LSB + IDX_W > ADDR_W)
         $error("index field does not fit in the address");
   end

   logic [ADDR_W-1:0] rel_addr;

   assign rel_addr = byte_addr - ADDR_W'(BASE_ADDR);
   assign word_idx = rel_addr[LSB +: IDX_W];

endmodule

// File: rtl/memadapt_ram.sv
module memadapt_ram #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 256,
   localparam int unsigned LANES = DATA_W / 8,
   localparam int unsigned IDX_W = $clog2(DEPTH),
   localparam int unsigned LEN_W = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [LEN_W-1:0]  len,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);
   import memadapt_pkg::*;

   logic [LANES-1:0] lane_en;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [7:0] bank [DEPTH];

      assign lane_en[g] = lane_selected(g, int'(len));

      always_ff @(posedge clk) begin
         if (wr_en && lane_en[g])
            bank[idx] <= wr_data[8*g +: 8];
      end

      assign rd_data[8*g +: 8] = bank[idx];
   end

endmodule

// File: rtl/memadapt_rspbuf.sv
module memadapt_rspbuf #(
   parameter int unsigned PAYLOAD_W = 43
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_fire,
   input  logic [PAYLOAD_W-1:0] in_payload,
   output logic                 in_rdy,
   output logic                 out_val,
   input  logic                 out_rdy,
   output logic [PAYLOAD_W-1:0] out_payload
);
   logic                 full_q;
   logic [PAYLOAD_W-1:0] entry_q;

   assign in_rdy      = !full_q || out_rdy;
   assign out_val     = full_q;
   assign out_payload = entry_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         full_q <= 1'b0;
      else if (in_fire)
         full_q <= 1'b1;
      else if (full_q && out_rdy)
         full_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         entry_q <= '0;
      else if (in_fire)
         entry_q <= in_payload;
   end

   // R3: held response stays put while stalled
   assert_hold_stalled_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out_val && !out_rdy |=> out_val && $stable(out_payload));

   // R3: an accepted request is visible next cycle
   assert_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_fire |=> out_val);

   // R4: draining with no refill empties the buffer
   assert_drain_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_val && out_rdy && !in_fire |=> !out_val);

   // R2: an empty buffer always accepts
   assert_empty_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !out_val |-> in_rdy);

endmodule

// File: rtl/memadapt_top.sv
module memadapt_top #(
   parameter int unsigned     ADDR_W    = 32,
   parameter int unsigned     DATA_W    = 32,
   parameter int unsigned     OPQ_W     = 8,
   parameter int unsigned     DEPTH     = 256,
   parameter longint unsigned BASE_ADDR = 64'h2000,
   localparam int unsigned    LANES     = DATA_W / 8,
   localparam int unsigned    LEN_W     = $clog2(LANES),
   localparam int unsigned    IDX_W     = $clog2(DEPTH),
   localparam int unsigned    PAYLOAD_W = 1 + OPQ_W + LEN_W + DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_val,
   output logic              req_rdy,
   input  logic              req_type,
   input  logic [OPQ_W-1:0]  req_opaque,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [DATA_W-1:0] req_data,
   output logic              rsp_val,
   input  logic              rsp_rdy,
   output logic              rsp_type,
   output logic [OPQ_W-1:0]  rsp_opaque,
   output logic [LEN_W-1:0]  rsp_len,
   output logic [DATA_W-1:0] rsp_data
);
   import memadapt_pkg::*;

   initial begin
      if (DATA_W % 8 != 0 || LANES < 2 || (1 << LEN_W) != LANES)
         $error("DATA_W must be a power-of-two number of bytes, at least two");
      if (DEPTH < 2 || (1 << IDX_W) != DEPTH)
         $error("DEPTH must be a power of two");
      if (BASE_ADDR % LANES != 0)
         $error("BASE_ADDR must be word aligned");
   end

   logic                 req_fire;
   logic [IDX_W-1:0]     word_idx;
   logic [DATA_W-1:0]    ram_rd;
   logic                 ram_we;
   logic [PAYLOAD_W-1:0] in_payload;
   logic [PAYLOAD_W-1:0] out_payload;

   assign req_fire = req_val && req_rdy;
   assign ram_we   = req_fire && (msg_kind_e'(req_type) == KIND_WRITE);

   memadapt_xlate #(
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR),
      .IDX_W     (IDX_W),
      .LSB       (LEN_W)
   ) u_xlate (
      .byte_addr (req_addr),
      .word_idx  (word_idx)
   );

   memadapt_ram #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_ram (
      .clk     (clk),
      .wr_en   (ram_we),
      .idx     (word_idx),
      .len     (req_len),
      .wr_data (req_data),
      .rd_data (ram_rd)
   );

   assign in_payload = {req_type, req_opaque, req_len, ram_rd};

   memadapt_rspbuf #(
      .PAYLOAD_W (PAYLOAD_W)
   ) u_rspbuf (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_fire     (req_fire),
      .in_payload  (in_payload),
      .in_rdy      (req_rdy),
      .out_val     (rsp_val),
      .out_rdy     (rsp_rdy),
      .out_payload (out_payload)
   );

   assign {rsp_type, rsp_opaque, rsp_len, rsp_data} = out_payload;

   // R1: a refused request means a response is held and stalled
   assert_refused_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_val && !req_rdy |-> rsp_val && !rsp_rdy);

   // R7: the kind of a taken request comes back on the response
   assert_echo_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_fire |=> rsp_type == $past(req_type) && rsp_opaque == $past(req_opaque));

endmodule

// File: tb/memadapt_top_tb.sv
module memadapt_top_tb;
   localparam int unsigned     ADDR_W = 32;
   localparam int unsigned     DATA_W = 32;
   localparam int unsigned     OPQ_W  = 8;
   localparam int unsigned     DEPTH  = 64;
   localparam longint unsigned BASE   = 64'h200;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              req_val, req_rdy, req_type;
   logic [OPQ_W-1:0]  req_opaque;
   logic [ADDR_W-1:0] req_addr;
   logic [1:0]        req_len;
   logic [DATA_W-1:0] req_data;
   logic              rsp_val, rsp_rdy, rsp_type;
   logic [OPQ_W-1:0]  rsp_opaque;
   logic [1:0]        rsp_len;
   logic [DATA_W-1:0] rsp_data;

   always #5 clk = ~clk;

   memadapt_top #(
      .ADDR_W (ADDR_W), .DATA_W (DATA_W), .OPQ_W (OPQ_W),
      .DEPTH (DEPTH), .BASE_ADDR (BASE)
   ) u_dut (
      .clk (clk), .rst_n (rst_n),
      .req_val (req_val), .req_rdy (req_rdy), .req_type (req_type),
      .req_opaque (req_opaque), .req_addr (req_addr), .req_len (req_len),
      .req_data (req_data),
      .rsp_val (rsp_val), .rsp_rdy (rsp_rdy), .rsp_type (rsp_type),
      .rsp_opaque (rsp_opaque), .rsp_len (rsp_len), .rsp_data (rsp_data)
   );

   int unsigned checks = 0;
   int unsigned errors = 0;
   bit          finished = 0;

   logic [DATA_W-1:0] mem_m [DEPTH];
   logic              m_full;
   logic              m_type;
   logic [OPQ_W-1:0]  m_opq;
   logic [1:0]        m_len;
   logic [DATA_W-1:0] m_data;

   function automatic int unsigned idx_of(input logic [ADDR_W-1:0] a);
      logic [ADDR_W-1:0] rel;
      rel = a - ADDR_W'(BASE);
      return (rel >> 2) % DEPTH;
   endfunction

   function automatic logic [DATA_W-1:0] merge(input logic [DATA_W-1:0] old_w,
                                                input logic [DATA_W-1:0] new_w,
                                                input logic [1:0] len);
      logic [DATA_W-1:0] r;
      r = old_w;
      for (int b = 0; b < 4; b++)
         if (len == 0 || b < int'(len)) r[8*b +: 8] = new_w[8*b +: 8];
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // called just after a falling edge; one full cycle, ends after the next falling edge
   task automatic step(input bit v, input bit t, input logic [OPQ_W-1:0] o,
                       input logic [ADDR_W-1:0] a, input logic [1:0] l,
                       input logic [DATA_W-1:0] d, input bit rr);
      bit fire;
      int unsigned ix;
      req_val = v; req_type = t; req_opaque = o; req_addr = a;
      req_len = l; req_data = d; rsp_rdy = rr;
      #1;
      check(req_rdy == (!m_full || rr), "R2 req_rdy", req_rdy, !m_full || rr);
      fire = v && req_rdy;
      if (fire) begin
         ix = idx_of(a);
         m_data = mem_m[ix];
         if (t) mem_m[ix] = merge(mem_m[ix], d, l);
         m_full = 1; m_type = t; m_opq = o; m_len = l;
      end else if (m_full && rr) begin
         m_full = 0;
      end
      @(posedge clk);
      @(negedge clk);
      check(rsp_val == m_full, "R3/R4 rsp_val", rsp_val, m_full);
      if (m_full) begin
         check(rsp_type == m_type && rsp_opaque == m_opq && rsp_len == m_len,
               "R7 echo", {rsp_type, rsp_opaque, rsp_len}, {m_type, m_opq, m_len});
         if (!m_type)
            check(rsp_data == m_data, "R5/R6/R7 read data", rsp_data, m_data);
      end
   endtask

   function automatic logic [ADDR_W-1:0] waddr(input int unsigned ix);
      return ADDR_W'(BASE) + ADDR_W'(ix * 4);
   endfunction

   initial begin
      #200000;
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4177));
      m_full = 0; m_type = 0; m_opq = '0; m_len = '0; m_data = '0;
      rst_n = 0; req_val = 0; req_type = 0; req_opaque = '0; req_addr = '0;
      req_len = '0; req_data = '0; rsp_rdy = 0;
      repeat (3) @(negedge clk);
      // R9: reset state
      check(rsp_val == 0, "R9 rsp_val in reset", rsp_val, 0);
      check(req_rdy == 1, "R9 req_rdy in reset", req_rdy, 1);
      rst_n = 1;
      @(negedge clk);
      check(rsp_val == 0 && req_rdy == 1, "R9 after reset", {rsp_val, req_rdy}, 2'b01);

      // preload every word with full-width writes, back to back (R4)
      for (int i = 0; i < int'(DEPTH); i++)
         step(1, 1, 8'(i), waddr(i), 2'd0, $urandom, 1);
      step(0, 0, 0, 0, 0, 0, 1);

      // R6: partial writes by length
      step(1, 1, 8'h11, waddr(5), 2'd0, 32'hAABBCCDD, 1);
      step(1, 1, 8'h12, waddr(5), 2'd1, 32'h11223344, 1);
      step(1, 1, 8'h13, waddr(5), 2'd3, 32'h55667788, 1);
      step(1, 0, 8'h14, waddr(5), 2'd2, 32'h0, 1);
      check(mem_m[5] == 32'hAA667788, "R6 model merge", mem_m[5], 32'hAA667788);

      // R5: aliasing one array length up and a wrap below the base
      step(1, 1, 8'h21, waddr(7 + DEPTH) + 2, 2'd0, 32'hCAFE0007, 1);
      step(1, 0, 8'h22, waddr(7), 2'd0, 32'h0, 1);
      step(1, 0, 8'h23, ADDR_W'(BASE) - 4, 2'd0, 32'h0, 1);

      // R8: read with junk data leaves the word
      step(1, 0, 8'h31, waddr(9), 2'd0, 32'hFFFFFFFF, 1);
      step(1, 0, 8'h32, waddr(9), 2'd0, 32'h0, 1);

      // R1: write offered while a response is stalled is refused
      step(1, 0, 8'h41, waddr(3), 2'd0, 32'h0, 0);
      step(1, 1, 8'h42, waddr(3), 2'd0, 32'hDEADBEEF, 0);
      step(1, 1, 8'h43, waddr(3), 2'd0, 32'hDEADBEEF, 0);
      step(0, 0, 0, 0, 0, 0, 1);
      step(1, 0, 8'h44, waddr(3), 2'd0, 32'h0, 1);
      step(0, 0, 0, 0, 0, 0, 1);

      // constrained random traffic
      for (int n = 0; n < 4000; n++) begin
         logic [ADDR_W-1:0] a;
         a = ADDR_W'(BASE) + ADDR_W'(($urandom % (2 * DEPTH)) * 4) + ADDR_W'($urandom % 4);
         if ($urandom % 16 == 0) a = ADDR_W'(BASE) - ADDR_W'((1 + $urandom % 8) * 4);
         step(($urandom % 4) != 0, $urandom % 2, 8'($urandom), a, 2'($urandom),
              $urandom, ($urandom % 3) != 0);
      end
      step(0, 0, 0, 0, 0, 0, 1);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule